// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 52-bit physical address by reading a four-level tree of translation tables from memory. A request carries the virtual address and the 40-bit frame number of the top table. Before it reads anything, the block checks that the address is in sign-extended (canonical) form. It then fetches one 64-bit entry per level and stops early when an entry marks a 1GB or 2MB page.

The result carries the physical address, a page-size code and a fault code. The request, result and memory-read channels are each valid/ready. A source holds valid and its payload until ready is seen at a clock edge. The block holds its memory read address while `mem_req_ready` is low, and it holds its result while `res_ready` is low. Only one walk is in flight at a time: `req_ready` stays low from the moment a request is accepted until its result has been taken. Memory responses are taken only while `mem_rsp_ready` is high, and at most one read is outstanding.

Fetch levels are counted in walk order: level 0 is the top table and level 3 is the final table. Bits 0 (present) and 7 (large page) of each entry are the only flag bits that are used.

Top module: `page_walker`

## Requirements
- R1: An address whose bits 63:47 are not all equal ends the walk with fault code 1, size 0 and address 0, and no memory read is issued.
- R2: The read for level L goes to the previous base (the request root for L=0, otherwise bits 51:12 of the level L-1 entry) in bits 51:12, virtual bits (47-9L):(39-9L) in bits 11:3, and zeros in bits 2:0. A walk that ends at level L issues exactly L+1 reads.
- R3: A present level-1 entry with bit 7 set ends the walk with size code 2 (1GB) and address {entry[51:30], va[29:0]}.
- R4: A present level-2 entry with bit 7 set ends the walk with size code 1 (2MB) and address {entry[51:21], va[20:0]}.
- R5: A present level-3 entry ends the walk with size code 0 (4KB) and address {entry[51:12], va[11:0]}.
- R6: An entry at level L whose bit 0 is clear ends the walk with fault code 4+L, size 0 and address 0. Fault code 0 means success.
- R7: Bit 7 has no effect in level-0 and level-3 entries.
- R8: A result stays valid and unchanged until it is taken. While a result is pending or a walk is running, `req_ready` is low and no request is accepted.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the read request stays asserted and its address does not change.
- R10: After reset, `req_ready` is high and `res_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 40 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker waiting for entry data |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 52 | Translated physical address |
| res_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| res_fault | output | 3 | 0 none, 1 non-canonical, 4..7 not present at level 0..3 |

## Verification
The bench builds the walker with its default parameters: 48 virtual bits, 52 physical bits, 9-bit indexes, 4KB pages and four levels. This is the only setting in which the 1GB and 2MB leaves fall at levels 1 and 2, and in which the canonical test covers bits 63:47. With it, every leaf level, a not-present entry at each of the four levels, and both halves of the canonical space are reachable. The memory model stalls reads and delays responses at random, so the hold rules of every channel are exercised.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} pw_state_t;

  localparam logic [2:0] FLT_NONE     = 3'd0;
  localparam logic [2:0] FLT_NONCANON = 3'd1;
  localparam logic [2:0] FLT_NP_BASE  = 3'd4;

  localparam int PRESENT_BIT = 0;
  localparam int LARGE_BIT   = 7;
  localparam int ENTRY_W     = 64;
endpackage

// File: rtl/pw_canon.sv
module pw_canon #(
  parameter int VA_W = 48
) (
  input  logic [63:0] va,
  output logic        ok
);
  localparam int TOP_W = 64 - VA_W + 1;
  logic [TOP_W-1:0] upper;
  assign upper = va[63:VA_W-1];
  assign ok = (&upper) | ~(|upper);
endmodule

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int BASE_W = PA_W - OFF_W
) (
  input  logic [63:0]       va,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [BASE_W-1:0] base,
  output logic [PA_W-1:0]   entry_addr
);
  localparam int LOW_W = OFF_W - IDX_W;
  logic [IDX_W-1:0] idx [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx[l] = va[VA_W-1-l*IDX_W -: IDX_W];
  end

  assign entry_addr = {base, idx[lvl], {LOW_W{1'b0}}};
endmodule

// File: rtl/pw_leaf_form.sv
module pw_leaf_form #(
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [63:0]      entry,
  input  logic [63:0]      va,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] cand [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int SH = OFF_W + IDX_W * (LEVELS - 1 - l);
    localparam logic [PA_W-1:0] MASK = (PA_W'(1) << SH) - PA_W'(1);
    assign cand[l] = (entry[PA_W-1:0] & ~MASK) | (va[PA_W-1:0] & MASK);
  end

  assign pa = cand[lvl];
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [63:0]           req_vaddr,
  input  logic [PA_W-OFF_W-1:0] req_root,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  output logic                  mem_rsp_ready,
  input  logic [63:0]           mem_rsp_data,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [PA_W-1:0]       res_paddr,
  output logic [1:0]            res_size,
  output logic [2:0]            res_fault
);
  localparam int BASE_W = PA_W - OFF_W;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  pw_state_t         st_q, st_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [63:0]       va_q, va_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic [1:0]        size_q, size_d;
  logic [2:0]        fault_q, fault_d;

  logic              canon_ok;
  logic [PA_W-1:0]   ent_addr;
  logic [PA_W-1:0]   leaf_pa;
  logic              ent_present, ent_large, large_ok, at_last;

  pw_canon #(.VA_W(VA_W)) u_canon (
    .va (req_vaddr),
    .ok (canon_ok)
  );

  pw_index_sel #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_index_sel (
    .va         (va_q),
    .lvl        (lvl_q),
    .base       (base_q),
    .entry_addr (ent_addr)
  );

  pw_leaf_form #(
    .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_leaf_form (
    .entry (mem_rsp_data),
    .va    (va_q),
    .lvl   (lvl_q),
    .pa    (leaf_pa)
  );

  assign ent_present = mem_rsp_data[PRESENT_BIT];
  assign ent_large   = mem_rsp_data[LARGE_BIT];
  assign at_last     = (lvl_q == LAST_LVL);
  // large pages are honoured only between the top and final tables
  assign large_ok    = ent_large && (lvl_q != '0) && !at_last;

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    va_d    = va_q;
    base_d  = base_q;
    pa_d    = pa_q;
    size_d  = size_q;
    fault_d = fault_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d   = req_vaddr;
          base_d = req_root;
          lvl_d  = '0;
          if (canon_ok) begin
            st_d = ST_ISSUE;
          end else begin
            st_d    = ST_DONE;
            pa_d    = '0;
            size_d  = 2'd0;
            fault_d = FLT_NONCANON;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!ent_present) begin
            st_d    = ST_DONE;
            pa_d    = '0;
            size_d  = 2'd0;
            fault_d = FLT_NP_BASE + 3'(lvl_q);
          end else if (large_ok || at_last) begin
            st_d    = ST_DONE;
            pa_d    = leaf_pa;
            size_d  = 2'(LEVELS - 1 - int'(lvl_q));
            fault_d = FLT_NONE;
          end else begin
            st_d   = ST_ISSUE;
            base_d = mem_rsp_data[PA_W-1:OFF_W];
            lvl_d  = lvl_q + LVL_W'(1);
          end
        end
      end
      ST_DONE: begin
        if (res_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      size_q  <= 2'd0;
      fault_q <= FLT_NONE;
    end else begin
      st_q    <= st_d;
      lvl_q   <= lvl_d;
      va_q    <= va_d;
      base_q  <= base_d;
      pa_q    <= pa_d;
      size_q  <= size_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = ent_addr;
  assign mem_rsp_ready = (st_q == ST_WAIT);
  assign res_valid     = (st_q == ST_DONE);
  assign res_paddr     = pa_q;
  assign res_size      = size_q;
  assign res_fault     = fault_q;
endmodule

// File: rtl/pw_walk_chk.sv
module pw_walk_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_paddr,
  input logic [1:0]      res_size,
  input logic [2:0]      res_fault
);
  logic read_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) read_seen <= 1'b0;
    else if (req_valid && req_ready) read_seen <= 1'b0;
    else if (mem_req_valid && mem_req_ready) read_seen <= 1'b1;
  end

  // R1
  noncanon_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 3'd1 |-> !read_seen);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 3'd0 |-> res_paddr == '0 && res_size == 2'd0);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr)
      && $stable(res_size) && $stable(res_fault));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid && !mem_rsp_ready);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  logic unused_ok;
  assign unused_ok = mem_rsp_valid;
endmodule

bind page_walker pw_walk_chk #(.PA_W(PA_W)) u_walk_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_paddr     (res_paddr),
  .res_size      (res_size),
  .res_fault     (res_fault)
);

// File: tb/page_walker_bench.sv
module page_walker_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_vaddr;
  logic [39:0] req_root;
  logic        mem_req_valid, mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        res_valid, res_ready;
  logic [51:0] res_paddr;
  logic [1:0]  res_size;
  logic [2:0]  res_fault;

  page_walker u_page_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_size(res_size), .res_fault(res_fault)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // memory model
  logic [63:0] mem [logic [51:0]];
  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  int unsigned req_cnt = 0;
  int unsigned rsp_cnt = 0;
  logic [51:0] act_addr [8];

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      act_addr[req_cnt % 8] <= mem_req_addr;
      req_cnt <= req_cnt + 1;
    end
    if (mem_rsp_valid && mem_rsp_ready) rsp_cnt <= rsp_cnt + 1;
  end

  initial begin
    int unsigned issued;
    logic        stall;
    logic [51:0] stall_a;
    issued = 0;
    stall = 1'b0;
    stall_a = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    mem_req_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (stall) begin
        // R9: a stalled read keeps its request and address
        chk("R9", "stalled read held", {11'd0, mem_req_valid, mem_req_addr},
            {11'd0, 1'b1, stall_a});
      end
      if (mem_rsp_valid && rsp_cnt == issued) mem_rsp_valid = 1'b0;
      if (!mem_rsp_valid && req_cnt > issued && $urandom_range(0, 2) == 0) begin
        mem_rsp_data = rd(act_addr[issued % 8]);
        mem_rsp_valid = 1'b1;
        issued++;
      end
      mem_req_ready = ($urandom_range(0, 3) != 0);
      stall = mem_req_valid && !mem_req_ready;
      stall_a = mem_req_addr;
    end
  end

  // builds a walk: leaf is the level where it ends, np the level made absent
  task automatic build(input logic [63:0] va, input logic [39:0] root,
                       input int leaf, input int np, input bit force_ps);
    logic [39:0] base;
    logic [51:0] a;
    logic [63:0] e;
    mem.delete();
    base = root;
    for (int l = 0; l < 4; l++) begin
      a = {base, va[47-9*l -: 9], 3'b000};
      e = {$urandom, $urandom};
      if (l == np) begin
        e[0] = 1'b0;
      end else begin
        e[0] = 1'b1;
        if (l == 1 || l == 2) e[7] = (l == leaf);
        else e[7] = force_ps ? 1'b1 : e[7];
      end
      mem[a] = e;
      if (l == np || l == leaf) break;
      base = e[51:12];
    end
  endtask

  task automatic ref_walk(input logic [63:0] va, input logic [39:0] root,
                          output logic [51:0] pa, output logic [1:0] sz,
                          output logic [2:0] flt, output int n,
                          output logic [51:0] ea [4]);
    logic [39:0] base;
    logic [63:0] e;
    pa = '0; sz = 2'd0; flt = 3'd0; n = 0;
    for (int l = 0; l < 4; l++) ea[l] = '0;
    if (!(&va[63:47] || ~|va[63:47])) begin
      flt = 3'd1;
      return;
    end
    base = root;
    for (int l = 0; l < 4; l++) begin
      ea[l] = {base, va[47-9*l -: 9], 3'b000};
      n = l + 1;
      e = rd(ea[l]);
      if (!e[0]) begin
        flt = 3'(4 + l);
        return;
      end
      if (l == 1 && e[7]) begin pa = {e[51:30], va[29:0]}; sz = 2'd2; return; end
      if (l == 2 && e[7]) begin pa = {e[51:21], va[20:0]}; sz = 2'd1; return; end
      if (l == 3) begin pa = {e[51:12], va[11:0]}; sz = 2'd0; return; end
      base = e[51:12];
    end
  endtask

  task automatic do_walk(input logic [63:0] va, input logic [39:0] root,
                         input int hold, input string tag);
    logic [51:0] epa, pa0;
    logic [1:0]  esz, sz0;
    logic [2:0]  eflt, f0;
    logic [51:0] ea [4];
    int          en;
    int unsigned s, s_hold;
    ref_walk(va, root, epa, esz, eflt, en, ea);
    @(negedge clk);
    s = req_cnt;
    req_valid = 1'b1;
    req_vaddr = va;
    req_root  = root;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    pa0 = res_paddr; sz0 = res_size; f0 = res_fault;
    if (hold > 0) begin
      s_hold = req_cnt;
      req_valid = 1'b1;
      req_vaddr = va ^ 64'h1000;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        // R8: result held, no new request accepted
        chk("R8", "held result", {res_valid, req_ready, res_fault, res_size, res_paddr},
            {1'b1, 1'b0, f0, sz0, pa0});
      end
      chk("R8", "no read while result pending", 64'(req_cnt - s_hold), 64'd0);
      req_valid = 1'b0;
    end
    chk(tag, "fault", 64'(res_fault), 64'(eflt));
    chk(tag, "size", 64'(res_size), 64'(esz));
    chk(tag, "paddr", 64'(res_paddr), 64'(epa));
    chk("R2", "read count", 64'(req_cnt - s), 64'(en));
    for (int i = 0; i < en && i < 4; i++)
      chk("R2", "entry address", 64'(act_addr[(s + i) % 8]), 64'(ea[i]));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R8", "result cleared after take", {63'd0, res_valid}, 64'd0);
  endtask

  function automatic string tag_of(input int leaf, input int np, input bit canon);
    if (!canon) return "R1";
    if (np < 4 && np <= leaf) return "R6";
    if (leaf == 1) return "R3";
    if (leaf == 2) return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [63:0] va;
    logic [39:0] root;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_root = '0;
    res_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "reset state", {61'd0, req_ready, res_valid, mem_req_valid}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after reset", {61'd0, req_ready, res_valid, mem_req_valid}, 64'b100);

    // R1: non-canonical, both halves
    build(64'h0001_0000_0000_0000, 40'h12345, 3, 9, 0);
    do_walk(64'h0001_0000_0000_0000, 40'h12345, 0, "R1");
    do_walk(64'h7FFF_8000_0000_0000, 40'h12345, 0, "R1");
    // R5: canonical upper half, 4KB
    va = 64'hFFFF_C123_4567_89AB;
    build(va, 40'hABCDE, 3, 9, 0);
    do_walk(va, 40'hABCDE, 0, "R5");
    // R6: absent at each level
    for (int l = 0; l < 4; l++) begin
      va = 64'h0000_2468_ACE1_3579;
      build(va, 40'h00777, 3, l, 0);
      do_walk(va, 40'h00777, 0, "R6");
    end
    // R3, R4
    va = 64'h0000_1357_9BDF_0246;
    build(va, 40'h55555, 1, 9, 0);
    do_walk(va, 40'h55555, 0, "R3");
    build(va, 40'h55555, 2, 9, 0);
    do_walk(va, 40'h55555, 0, "R4");
    // R7: large flag set in top and final entries is ignored
    va = 64'hFFFF_8765_4321_0FED;
    build(va, 40'h0F0F0, 3, 9, 1);
    do_walk(va, 40'h0F0F0, 0, "R7");
    // R8: result back-pressure
    build(va, 40'h0F0F0, 2, 9, 0);
    do_walk(va, 40'h0F0F0, 4, "R8");

    for (int t = 0; t < 300; t++) begin
      int  leaf, np;
      bit  canon;
      leaf = $urandom_range(1, 3);
      np = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 3) : 9;
      va = {{16{1'b0}}, $urandom_range(0, 65535), $urandom};
      va = va[47] ? {16'hFFFF, va[47:0]} : va;
      canon = 1'b1;
      if ($urandom_range(0, 7) == 0) begin
        va[48 + $urandom_range(0, 15)] ^= 1'b1;
        canon = 1'b0;
      end
      root = {$urandom_range(0, 255), $urandom};
      build(va, root, leaf, np, 1'($urandom_range(0, 1)));
      do_walk(va, root, ($urandom_range(0, 9) == 0) ? 2 : 0, tag_of(leaf, np, canon));
    end
    report();
  end
endmodule